// File: doc/BRIEF.md
# Biphase-Mark Audio Sub-Frame Encoder

The encoder turns one audio sub-frame into a self-clocking line signal on a complementary output pair. Each sub-frame has 32 slots. Four slots carry a synchronization preamble. Twenty-four slots carry the sample word, sent least significant bit first; its four lowest bits take the auxiliary positions. Three slots carry the validity, user and channel-status flags. The last slot carries an even-parity bit that the block computes itself.

The clock runs at twice the bit rate, so one clock cycle is one half-bit cell and a sub-frame lasts 64 cycles. After each preamble the slots are biphase-mark coded. The preamble is one of three fixed eight-half-bit patterns that break the coding rule, so a receiver can find the sub-frame edge. The selector picks the pattern for a block-start sub-frame, an ordinary left sub-frame or a right sub-frame.

The surrounding logic presents the next sub-frame's inputs while `done_o` is high. The encoder samples them on the clock edge that ends that cycle, and sub-frames follow each other with no gap. Ordering frames and building channel-status blocks are left to that logic.

Top module: `sf_bmc_encoder`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first rising clock edge, `txp_o` and `txn_o` are both 0.
- R2: From the first rising edge after reset release, `txn_o` is the inverse of `txp_o` in every cycle.
- R3: A sub-frame lasts exactly 64 clock cycles, one half-bit per cycle. `done_o` is high only in the cycle that shows the last half-bit. Inputs are sampled on the edge that ends a `done_o` cycle, and on the first edge after reset release.
- R4: Half-bits 0..7, first to last, follow the pattern chosen by `pre_sel_i`: 0 block start `11101000`, 1 left `11100010`, 2 right `11100100`, 3 treated as 1. The pattern is sent as written when the line was low just before the sub-frame, and inverted otherwise.
- R5: Slots 4..27 carry `data_i` least significant bit first: bit 0 is in slot 4 and bit 23 is in slot 27.
- R6: Slot 28 carries `valid_i`, slot 29 carries `user_i` and slot 30 carries `chstat_i`.
- R7: Slot 31 carries a parity bit that makes the number of ones in slots 4..31 even.
- R8: Slot s (4..31) covers half-bits 2s and 2s+1. The first half-bit inverts the line level of the half-bit before it. The second half-bit repeats the first for a 0 and inverts it for a 1.
- R9: Asserting reset in the middle of a sub-frame aborts it at once. After release, a fresh sub-frame starts from a low line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-bit clock (twice the bit rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 24 | Auxiliary and audio bits for slots 4..27, LSB first |
| valid_i | input | 1 | Validity flag for slot 28 |
| user_i | input | 1 | User bit for slot 29 |
| chstat_i | input | 1 | Channel-status bit for slot 30 |
| pre_sel_i | input | 2 | Preamble selector: 0 block start, 1 left, 2 right, 3 left |
| txp_o | output | 1 | Line output, true polarity |
| txn_o | output | 1 | Line output, inverted polarity |
| done_o | output | 1 | High in the cycle showing a sub-frame's last half-bit |

## Verification
Several rules are checked by assertions on every cycle:
- the pair stays complementary;
- the half-bit counter wraps after 64 cycles, and `done_o` never stays high for two cycles in a row;
- every cell boundary in the data region carries a transition;
- the first three preamble half-bits hold one level;
- every latched word has even parity over slots 4..31.

Only the bench's scenarios show the exact preamble patterns and the slot positions of the sample and flag bits. They also show the unused selector code and the all-zero and all-one data extremes. The bench decodes the captured waveform back into bits to check these. The same applies to output behaviour during reset, just after release and after an abort in the middle of a sub-frame.

// File: rtl/sf_pkg.sv
`timescale 1ns/1ps
package sf_pkg;
  localparam int SLOTS    = 32;
  localparam int HALVES   = 2 * SLOTS;
  localparam int HB_W     = $clog2(HALVES);
  localparam int PRE_HB   = 8;             // preamble half-bits
  localparam int AUX_LO   = 4;             // first coded slot
  localparam int DATA_W   = 24;            // slots 4..27
  localparam int SLOT_V   = AUX_LO + DATA_W;

  typedef enum logic [1:0] {
    PRE_BLK  = 2'd0,
    PRE_LEFT = 2'd1,
    PRE_RGT  = 2'd2,
    PRE_ALT  = 2'd3
  } pre_e;

  // MSB is transmitted first; assumes line was low beforehand
  function automatic logic [PRE_HB-1:0] pre_pattern(input logic [1:0] sel);
    case (sel)
      PRE_BLK: pre_pattern = 8'b1110_1000;
      PRE_RGT: pre_pattern = 8'b1110_0100;
      default: pre_pattern = 8'b1110_0010;
    endcase
  endfunction
endpackage

// File: rtl/sf_frame_pack.sv
`timescale 1ns/1ps
module sf_frame_pack
  import sf_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              user_i,
  input  logic              chstat_i,
  output logic [SLOTS-1:0]  word_o
);
  logic par;

  // even parity over slots 4..31
  assign par    = ^{data_i, valid_i, user_i, chstat_i};
  assign word_o = {par, chstat_i, user_i, valid_i, data_i, {AUX_LO{1'b0}}};
endmodule

// File: rtl/sf_slot_timer.sv
`timescale 1ns/1ps
module sf_slot_timer
  import sf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [HB_W-1:0] nxt_hb_o,
  output logic            load_o,
  output logic            en_o,
  output logic            done_o
);
  localparam logic [HB_W-1:0] LAST = HB_W'(HALVES - 1);

  logic [HB_W-1:0] hb_q;
  logic            en_q;

  assign load_o   = (hb_q == LAST);
  assign nxt_hb_o = load_o ? '0 : hb_q + HB_W'(1);
  assign en_o     = en_q;
  assign done_o   = en_q && load_o;

  // reset to LAST so the first edge loads sub-frame 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb_q <= LAST;
      en_q <= 1'b0;
    end else begin
      hb_q <= nxt_hb_o;
      en_q <= 1'b1;
    end
  end

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hb_q == LAST) |=> (hb_q == '0));

  p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/sf_line_coder.sv
`timescale 1ns/1ps
module sf_line_coder
  import sf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [HB_W-1:0] nxt_hb_i,
  input  logic [SLOTS-1:0] word_i,
  input  logic [1:0]      pre_i,
  output logic            line_o
);
  logic [SLOTS-1:0]  word_q, cur_word;
  logic [1:0]        pre_q, cur_pre;
  logic              pol_q, cur_pol;
  logic              line_q, line_d;
  logic [PRE_HB-1:0] pat;

  assign cur_word = load_i ? word_i : word_q;
  assign cur_pre  = load_i ? pre_i  : pre_q;
  assign cur_pol  = load_i ? line_q : pol_q;
  assign pat      = pre_pattern(cur_pre);

  always_comb begin
    if (nxt_hb_i < HB_W'(PRE_HB))
      line_d = pat[3'd7 - nxt_hb_i[2:0]] ^ cur_pol;
    else if (!nxt_hb_i[0])
      line_d = ~line_q;                                   // cell boundary
    else
      line_d = cur_word[nxt_hb_i[HB_W-1:1]] ? ~line_q : line_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      pre_q  <= '0;
      pol_q  <= 1'b0;
      line_q <= 1'b0;
    end else begin
      line_q <= line_d;
      if (load_i) begin
        word_q <= word_i;
        pre_q  <= pre_i;
        pol_q  <= line_q;
      end
    end
  end

  assign line_o = line_q;

  p_cell_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nxt_hb_i >= HB_W'(PRE_HB) && !nxt_hb_i[0]) |=> (line_q != $past(line_q)));

  p_pre_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nxt_hb_i == HB_W'(1) || nxt_hb_i == HB_W'(2)) |=> (line_q == $past(line_q)));

  p_even_par_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (^word_q[SLOTS-1:AUX_LO] == 1'b0));
endmodule

// File: rtl/sf_bmc_encoder.sv
`timescale 1ns/1ps
module sf_bmc_encoder
  import sf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              user_i,
  input  logic              chstat_i,
  input  logic [1:0]        pre_sel_i,
  output logic              txp_o,
  output logic              txn_o,
  output logic              done_o
);
  logic [SLOTS-1:0] word;
  logic [HB_W-1:0]  nxt_hb;
  logic             load, en, line;

  sf_frame_pack u_pack (
    .data_i   (data_i),
    .valid_i  (valid_i),
    .user_i   (user_i),
    .chstat_i (chstat_i),
    .word_o   (word)
  );

  sf_slot_timer u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .nxt_hb_o (nxt_hb),
    .load_o   (load),
    .en_o     (en),
    .done_o   (done_o)
  );

  sf_line_coder u_coder (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .nxt_hb_i (nxt_hb),
    .word_i   (word),
    .pre_i    (pre_sel_i),
    .line_o   (line)
  );

  // both legs grounded until the first edge after reset
  assign txp_o = en & line;
  assign txn_o = en & ~line;

  p_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (txp_o != txn_o));
endmodule

// File: tb/sf_bmc_encoder_tb_top.sv
`timescale 1ns/1ps
module sf_bmc_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [23:0] data_i;
  logic        valid_i, user_i, chstat_i;
  logic [1:0]  pre_sel_i;
  logic        txp_o, txn_o, done_o;

  int n_chk = 0;
  int n_err = 0;
  bit lvl   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sf_bmc_encoder dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .valid_i(valid_i),
    .user_i(user_i), .chstat_i(chstat_i), .pre_sel_i(pre_sel_i),
    .txp_o(txp_o), .txn_o(txn_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat_of(input logic [1:0] s);
    case (s)
      2'd0:    pat_of = 8'b1110_1000;
      2'd2:    pat_of = 8'b1110_0100;
      default: pat_of = 8'b1110_0010;
    endcase
  endfunction

  // drive inputs (sampled at next posedge), capture 64 half-bits, check
  task automatic run_frame(input logic [23:0] d, input bit v, input bit u,
                           input bit c, input logic [1:0] sel);
    logic [63:0] w, dn;
    logic [7:0]  ep, pat;
    logic [31:0] bits;
    bit          pair_ok, cell_ok, par_exp;
    int          ones;
    data_i = d; valid_i = v; user_i = u; chstat_i = c; pre_sel_i = sel;
    pair_ok = 1'b1; cell_ok = 1'b1; bits = '0; ones = 0;
    for (int h = 0; h < 64; h++) begin
      @(negedge clk);
      w[h]  = txp_o;
      dn[h] = done_o;
      if (txn_o !== ~txp_o) pair_ok = 1'b0;
    end
    chk(pair_ok, "R2", "txn complement", {63'd0, txn_o}, {63'd0, ~txp_o});
    chk(dn == 64'h8000_0000_0000_0000, "R3", "done timing", dn, 64'h8000_0000_0000_0000);
    pat = pat_of(sel);
    for (int h = 0; h < 8; h++) ep[h] = pat[7-h] ^ lvl;
    chk(w[7:0] == ep, "R4", "preamble", {56'd0, w[7:0]}, {56'd0, ep});
    for (int s = 4; s < 32; s++) begin
      if (w[2*s] == w[2*s-1]) cell_ok = 1'b0;
      bits[s] = w[2*s] ^ w[2*s+1];
      if (bits[s]) ones++;
    end
    chk(cell_ok, "R8", "cell boundary transitions", w, 64'd0);
    chk(bits[27:4] == d, "R5", "sample bits", {40'd0, bits[27:4]}, {40'd0, d});
    chk(bits[30:28] == {c, u, v}, "R6", "flag slots", {61'd0, bits[30:28]}, {61'd0, c, u, v});
    par_exp = ^{d, v, u, c};
    chk(bits[31] == par_exp && (ones % 2) == 0, "R7", "parity slot",
        {63'd0, bits[31]}, {63'd0, par_exp});
    lvl = w[63];
  endtask

  task automatic t_reset_entry();
    rst_ni = 1'b1;
    data_i = '0; valid_i = 0; user_i = 0; chstat_i = 0; pre_sel_i = 2'd0;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(!txp_o && !txn_o, "R1", "outputs in reset", {62'd0, txp_o, txn_o}, 64'd0);
    rst_ni = 1'b1;
    #2;
    chk(!txp_o && !txn_o, "R1", "outputs before first edge", {62'd0, txp_o, txn_o}, 64'd0);
    lvl = 1'b0;
  endtask

  task automatic t_block_start_zero();
    run_frame(24'h000000, 1'b0, 1'b0, 1'b0, 2'd0);  // R4 block start, R5 zeros
  endtask

  task automatic t_left_all_ones();
    run_frame(24'hFFFFFF, 1'b1, 1'b1, 1'b1, 2'd1);
  endtask

  task automatic t_right_mixed();
    run_frame(24'hA5_3C96, 1'b0, 1'b1, 1'b0, 2'd2);
    run_frame(24'h12_3457, 1'b1, 1'b0, 1'b1, 2'd1);
    run_frame(24'h80_0001, 1'b0, 1'b0, 1'b1, 2'd2);
  endtask

  task automatic t_code3_as_left();
    run_frame(24'h5A_0F0F, 1'b1, 1'b0, 1'b0, 2'd3);  // R4 code 3 -> left pattern
  endtask

  task automatic t_abort_mid_frame();
    data_i = 24'hFF00FF; valid_i = 1; user_i = 1; chstat_i = 0; pre_sel_i = 2'd1;
    repeat (20) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(!txp_o && !txn_o, "R9", "abort grounds outputs", {62'd0, txp_o, txn_o}, 64'd0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    lvl = 1'b0;
    run_frame(24'h0F1E2D, 1'b0, 1'b1, 1'b1, 2'd0);  // R9 fresh sub-frame
  endtask

  initial begin
    t_reset_entry();
    t_block_start_zero();
    t_left_all_ones();
    t_right_mixed();
    t_code3_as_left();
    t_abort_mid_frame();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule